// File: doc/BRIEF.md
# PCI Configuration Target with Software Interrupt Port

This block is a minimal PCI function-0 endpoint. It has a byte-wide configuration access port and a small I/O window. The configuration side holds:

- four fixed identifier bytes, which are also mirrored higher in the header;
- a two-bit command register;
- a 16-bit I/O base address register aligned to 32 bytes;
- a freely writable interrupt line byte;
- a fixed interrupt pin value that selects INTA.

Byte 0x08 returns a slot number taken from an input pin in place of a revision code. Any access that names a nonzero function reads all-ones and changes nothing.

Once software has enabled I/O decode and programmed a nonzero base, the block claims the 32-byte window at that base. It returns identifier and interrupt bytes at fixed offsets. A write to offset 6 sets an interrupt latch that drives `irq_out`. A read of offset 6 returns the latch and then clears it. System software can use this to find which slot raises which interrupt line.

Top module: `pcicfg_io_target`

## Requirements
- R1: Configuration bytes 0x00, 0x01, 0x02, 0x03 read 0x1A, 0x07, 0x0B, 0xAB (function 0). Bytes 0x2C to 0x2F read the same four values in the same order.
- R2: With `cfg_func` nonzero, `cfg_rdata` is 0xFF, and writes change no register.
- R3: Byte 0x04 stores only bits 1:0 of a write and reads them back with bits 7:2 zero. Bit 0 is the I/O decode enable.
- R4: Byte 0x10 stores only bits 7:5 of a write and reads back with bits 4:1 zero and bit 0 set. Byte 0x11 stores a full byte. The I/O base is {byte 0x11, byte 0x10 bits 7:5, 5'b0}. Bytes 0x12 and 0x13 read 0x00.
- R5: Byte 0x08 reads `slot_id`. Byte 0x3D reads 0x01. Byte 0x3C is read/write over all 8 bits.
- R6: Every other configuration byte reads 0x00 and ignores writes; this includes 0x05, 0x06, 0x07, 0x0A and 0x0B.
- R7: `io_hit` is high only when all of the following hold: `io_rd` or `io_wr` is high, command bit 0 is set, the base is nonzero, and `io_addr[15:5]` equals base bits 15:5.
- R8: On a hit, `io_rdata` depends on the offset `io_addr[4:0]`. Offsets 0 to 3 give the identifier bytes of R1, offset 4 the interrupt line, offset 5 0x01, and offset 6 the latch in bit 0 with other bits zero. Every other offset reads 0xFF. Without a hit, `io_rdata` is 0xFF.
- R9: A hit write to offset 6 sets the latch, and `irq_out` is high from the following cycle.
- R10: A hit read of offset 6 returns the current latch value, and `irq_out` is low from the following cycle. If a read and a write reach offset 6 in the same cycle, the clear takes priority.
- R11: Reset (`rst_n` low) clears the latch, the command, the base and the interrupt line. After reset, `irq_out` is low and no I/O access hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_id | input | 8 | Slot number returned at configuration byte 0x08 |
| cfg_func | input | 3 | Function number of the configuration access |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| io_addr | input | 16 | I/O address |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_rdata | output | 8 | I/O read data (combinational) |
| io_hit | output | 1 | Access falls inside the enabled window |
| irq_out | output | 1 | INTA-style interrupt, driven by the latch |

## Verification
A wrong command or base bit shows up in two places at the ports. It appears on the next configuration read of byte 0x04 or 0x10/0x11. It also appears as a missing or extra `io_hit` in the same cycle as the next I/O strobe near the window edges. A wrong latch state shows on `irq_out` one cycle after the offending offset-6 access. It also shows in bit 0 of the next offset-6 read. Register corruption from a nonzero function or an undefined byte stays hidden until a later function-0 readback, so the sweeps read every byte after each write pass.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;

  localparam logic [7:0] INT_PIN_A = 8'h01;

  // Identifier byte at position idx of the fixed four-byte header word.
  function automatic logic [7:0] ident_byte(input logic [1:0] idx);
    case (idx)
      2'd0:    return 8'h1A;
      2'd1:    return 8'h07;
      2'd2:    return 8'h0B;
      default: return 8'hAB;
    endcase
  endfunction

  // True when a configuration byte address carries an identifier byte.
  function automatic logic is_ident_addr(input logic [7:0] a);
    return (a[7:2] == 6'h00) || (a[7:2] == 6'h0B);
  endfunction

endpackage

// File: rtl/pcicfg_space.sv
module pcicfg_space
  import pcicfg_pkg::*;
#(
  parameter int FUNC_W   = 3,
  parameter int WIN_BITS = 5,
  localparam int LO_W    = 8 - WIN_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        slot_id,
  input  logic [FUNC_W-1:0] func,
  input  logic [7:0]        addr,
  input  logic              we,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              io_enable,
  output logic [15:0]       io_base,
  output logic [7:0]        int_line
);

  logic [1:0]      cmd_q;
  logic [LO_W-1:0] bar_lo_q;
  logic [7:0]      bar_hi_q;
  logic [7:0]      line_q;

  // Named decode events
  logic fn0_sel;
  logic wr_cmd, wr_bar_lo, wr_bar_hi, wr_line;

  assign fn0_sel   = (func == '0);
  assign wr_cmd    = fn0_sel && we && (addr == 8'h04);
  assign wr_bar_lo = fn0_sel && we && (addr == 8'h10);
  assign wr_bar_hi = fn0_sel && we && (addr == 8'h11);
  assign wr_line   = fn0_sel && we && (addr == 8'h3C);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      bar_lo_q <= '0;
      bar_hi_q <= '0;
      line_q   <= '0;
    end else begin
      if (wr_cmd)    cmd_q    <= wdata[1:0];
      if (wr_bar_lo) bar_lo_q <= wdata[7:WIN_BITS];
      if (wr_bar_hi) bar_hi_q <= wdata;
      if (wr_line)   line_q   <= wdata;
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (!fn0_sel) begin
      rdata = 8'hFF;
    end else if (is_ident_addr(addr)) begin
      rdata = ident_byte(addr[1:0]);
    end else begin
      case (addr)
        8'h04:   rdata = {6'b0, cmd_q};
        8'h08:   rdata = slot_id;
        8'h10:   rdata = {bar_lo_q, {(WIN_BITS-1){1'b0}}, 1'b1};
        8'h11:   rdata = bar_hi_q;
        8'h3C:   rdata = line_q;
        8'h3D:   rdata = INT_PIN_A;
        default: rdata = 8'h00;
      endcase
    end
  end

  assign io_enable = cmd_q[0];
  assign io_base   = {bar_hi_q, bar_lo_q, {WIN_BITS{1'b0}}};
  assign int_line  = line_q;

  // R2
  assert property (@(posedge clk) disable iff (!rst_n)
    (!fn0_sel) |-> (rdata == 8'hFF)) else $error("fn_nonzero_read_chk");

  // R2
  assert property (@(posedge clk) disable iff (!rst_n)
    (we && !fn0_sel) |=> ($stable(io_base) && $stable(int_line) && $stable(io_enable)))
    else $error("fn_nonzero_write_chk");

  // R3
  assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd |=> (io_enable == $past(wdata[0]))) else $error("cmd_store_chk");

  // R4
  assert property (@(posedge clk) disable iff (!rst_n)
    wr_bar_lo |=> (io_base[7:0] == ($past(wdata) & 8'hE0))) else $error("bar_lo_mask_chk");

endmodule

// File: rtl/pcicfg_io_window.sv
module pcicfg_io_window
  import pcicfg_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int WIN_BITS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_enable,
  input  logic [ADDR_W-1:0] io_base,
  input  logic [7:0]        int_line,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  output logic [7:0]        io_rdata,
  output logic              io_hit,
  output logic              irq_out
);

  localparam logic [WIN_BITS-1:0] IRQ_OFF  = WIN_BITS'(6);
  localparam logic [WIN_BITS-1:0] LINE_OFF = WIN_BITS'(4);
  localparam logic [WIN_BITS-1:0] PIN_OFF  = WIN_BITS'(5);

  logic [WIN_BITS-1:0] offset;
  logic win_match, irq_set_ev, irq_clr_ev, latch_q;

  assign offset     = io_addr[WIN_BITS-1:0];
  assign win_match  = io_enable && (io_base != '0) &&
                      (io_addr[ADDR_W-1:WIN_BITS] == io_base[ADDR_W-1:WIN_BITS]);
  assign io_hit     = win_match && (io_rd || io_wr);
  assign irq_clr_ev = win_match && io_rd && (offset == IRQ_OFF);
  assign irq_set_ev = win_match && io_wr && (offset == IRQ_OFF) && !latch_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          latch_q <= 1'b0;
    else if (irq_clr_ev) latch_q <= 1'b0;
    else if (irq_set_ev) latch_q <= 1'b1;
  end

  always_comb begin
    io_rdata = 8'hFF;
    if (io_hit) begin
      if (offset < WIN_BITS'(4))  io_rdata = ident_byte(offset[1:0]);
      else if (offset == LINE_OFF) io_rdata = int_line;
      else if (offset == PIN_OFF)  io_rdata = INT_PIN_A;
      else if (offset == IRQ_OFF)  io_rdata = {7'b0, latch_q};
    end
  end

  assign irq_out = latch_q;

  // R7
  assert property (@(posedge clk) disable iff (!rst_n)
    io_hit |-> (io_enable && io_base != '0)) else $error("hit_needs_enable_chk");

  // R9
  assert property (@(posedge clk) disable iff (!rst_n)
    (irq_set_ev && !irq_clr_ev) |=> irq_out) else $error("irq_raise_chk");

  // R10
  assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr_ev |=> !irq_out) else $error("irq_clear_chk");

  // R10
  assert property (@(posedge clk) disable iff (!rst_n)
    (!io_hit) |=> $stable(irq_out)) else $error("irq_hold_chk");

endmodule

// File: rtl/pcicfg_io_target.sv
module pcicfg_io_target
  import pcicfg_pkg::*;
#(
  parameter int FUNC_W   = 3,
  parameter int ADDR_W   = 16,
  parameter int WIN_BITS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        slot_id,
  input  logic [FUNC_W-1:0] cfg_func,
  input  logic [7:0]        cfg_addr,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  output logic [7:0]        io_rdata,
  output logic              io_hit,
  output logic              irq_out
);

  logic              io_enable;
  logic [ADDR_W-1:0] io_base;
  logic [7:0]        int_line;

  pcicfg_space #(.FUNC_W(FUNC_W), .WIN_BITS(WIN_BITS)) u_space (
    .clk(clk), .rst_n(rst_n), .slot_id(slot_id),
    .func(cfg_func), .addr(cfg_addr), .we(cfg_we), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .io_enable(io_enable), .io_base(io_base),
    .int_line(int_line)
  );

  pcicfg_io_window #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_window (
    .clk(clk), .rst_n(rst_n), .io_enable(io_enable), .io_base(io_base),
    .int_line(int_line), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_rdata(io_rdata), .io_hit(io_hit), .irq_out(irq_out)
  );

  // R11
  assert property (@(posedge clk)
    $rose(rst_n) |-> (!irq_out && !io_enable)) else $error("reset_state_chk");

endmodule

// File: tb/test_pcicfg_io_target.sv
module test_pcicfg_io_target;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [7:0]  slot_id;
  logic [2:0]  cfg_func;
  logic [7:0]  cfg_addr, cfg_wdata, cfg_rdata;
  logic        cfg_we;
  logic [15:0] io_addr;
  logic        io_rd, io_wr, io_hit, irq_out;
  logic [7:0]  io_rdata;

  pcicfg_io_target i_pcicfg_io_target (
    .clk(clk), .rst_n(rst_n), .slot_id(slot_id),
    .cfg_func(cfg_func), .cfg_addr(cfg_addr), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_rdata(io_rdata), .io_hit(io_hit), .irq_out(irq_out)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model state
  logic [1:0] m_cmd;
  logic [7:0] m_bar0, m_bar1, m_line;
  logic       m_irq;

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] id_val(input int i);
    logic [7:0] ids [4] = '{8'h1A, 8'h07, 8'h0B, 8'hAB};
    return ids[i];
  endfunction

  function automatic logic [7:0] exp_cfg(input int a);
    if (a < 4)                return id_val(a);
    if (a >= 44 && a < 48)    return id_val(a - 44);
    if (a == 4)               return {6'b0, m_cmd};
    if (a == 8)               return slot_id;
    if (a == 16)              return m_bar0 | 8'h01;
    if (a == 17)              return m_bar1;
    if (a == 60)              return m_line;
    if (a == 61)              return 8'h01;
    return 8'h00;
  endfunction

  function automatic logic [7:0] exp_io(input int off);
    if (off < 4)  return id_val(off);
    if (off == 4) return m_line;
    if (off == 5) return 8'h01;
    if (off == 6) return {7'b0, m_irq};
    return 8'hFF;
  endfunction

  function automatic logic [15:0] m_base();
    return {m_bar1, m_bar0[7:5], 5'b0};
  endfunction

  task automatic cfg_write(input logic [2:0] f, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_func = f; cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [2:0] f, input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    cfg_func = f; cfg_addr = a; cfg_we = 1'b0;
    #1 d = cfg_rdata;
  endtask

  task automatic io_access(input logic [15:0] a, input logic rd, input logic wr,
                           output logic hit, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = rd; io_wr = wr;
    #1 hit = io_hit; d = io_rdata;
    @(negedge clk);
    io_rd = 1'b0; io_wr = 1'b0;
  endtask

  task automatic model_write(input int a, input logic [7:0] v);
    if (a == 4)  m_cmd  = v[1:0];
    if (a == 16) m_bar0 = v & 8'hE0;
    if (a == 17) m_bar1 = v;
    if (a == 60) m_line = v;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_cmd = 0; m_bar0 = 0; m_bar1 = 0; m_line = 0; m_irq = 0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=complete");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic       h;
    rst_n = 1'b0; slot_id = 8'h0D; cfg_func = 0; cfg_addr = 0; cfg_we = 0;
    cfg_wdata = 0; io_addr = 0; io_rd = 0; io_wr = 0;
    do_reset();

    // R11 / R1 / R3 / R4 / R5 / R6: full read sweep after reset
    chk("R11", "irq after reset", irq_out, 0);
    for (int a = 0; a < 256; a++) begin
      cfg_read(0, 8'(a), d);
      chk("R1/R5/R6", $sformatf("reset cfg[%02h]", a), d, exp_cfg(a));
    end

    // R2: nonzero functions read FF and ignore writes
    for (int f = 1; f < 8; f++) begin
      cfg_write(3'(f), 8'h3C, 8'h77);
      cfg_write(3'(f), 8'h04, 8'h03);
      cfg_write(3'(f), 8'h11, 8'h55);
      for (int a = 0; a < 64; a += 4) begin
        cfg_read(3'(f), 8'(a), d);
        chk("R2", $sformatf("fn%0d cfg[%02h]", f, a), d, 8'hFF);
      end
    end
    for (int a = 0; a < 64; a++) begin
      cfg_read(0, 8'(a), d);
      chk("R2", $sformatf("fn0 after fn>0 writes cfg[%02h]", a), d, exp_cfg(a));
    end

    // R3 R4 R5 R6: write every byte, then sweep readback
    for (int a = 0; a < 256; a++) begin
      logic [7:0] v;
      v = 8'(a) ^ 8'hA5;
      if (a == 4) v = 8'hFC;         // command stays disabled during the sweep
      cfg_write(0, 8'(a), v);
      model_write(a, v);
    end
    for (int a = 0; a < 256; a++) begin
      cfg_read(0, 8'(a), d);
      chk("R3/R4/R6", $sformatf("after write cfg[%02h]", a), d, exp_cfg(a));
    end
    // R4: each byte-0x10 pattern masked to bits 7:5 plus bit 0
    for (int v = 0; v < 256; v += 7) begin
      cfg_write(0, 8'h10, 8'(v)); model_write(16, 8'(v));
      cfg_read(0, 8'h10, d);
      chk("R4", $sformatf("bar0 write %02h", v), d, exp_cfg(16));
    end

    // R7: decode disabled, then base zero
    cfg_write(0, 8'h10, 8'h40); model_write(16, 8'h40);
    cfg_write(0, 8'h11, 8'h12); model_write(17, 8'h12);
    cfg_write(0, 8'h3C, 8'h0E); model_write(60, 8'h0E);
    io_access(16'h1240, 1, 0, h, d);
    chk("R7", "cmd off no hit", h, 0);
    chk("R8", "no hit data", d, 8'hFF);
    cfg_write(0, 8'h04, 8'h03); model_write(4, 8'h03);
    cfg_read(0, 8'h04, d);
    chk("R3", "cmd readback", d, 8'h03);

    // R7 R8: sweep whole window plus neighbours
    for (int off = -2; off < 34; off++) begin
      logic [15:0] a;
      logic inwin;
      a = 16'(int'(m_base()) + off);
      inwin = (off >= 0) && (off < 32);
      io_access(a, 1, 0, h, d);
      chk("R7", $sformatf("hit off %0d", off), h, inwin);
      chk("R8", $sformatf("data off %0d", off), d, inwin ? exp_io(off) : 8'hFF);
    end
    // no strobe -> no hit
    io_access(16'h1240, 0, 0, h, d);
    chk("R7", "no strobe no hit", h, 0);

    // R9: write offset 6 raises irq
    io_access(16'h1246, 0, 1, h, d); m_irq = 1;
    chk("R9", "irq raised", irq_out, 1);
    io_access(16'h1246, 0, 1, h, d);
    chk("R9", "irq stays set", irq_out, 1);
    // R10: read returns 1 then clears
    io_access(16'h1246, 1, 0, h, d);
    chk("R10", "read returns latch", d, 8'h01);
    m_irq = 0;
    chk("R10", "irq cleared", irq_out, 0);
    io_access(16'h1246, 1, 0, h, d);
    chk("R10", "second read", d, 8'h00);
    // R10: simultaneous read and write: clear wins
    io_access(16'h1246, 0, 1, h, d);
    io_access(16'h1246, 1, 1, h, d);
    chk("R10", "rd+wr clear wins", irq_out, 0);
    io_access(16'h1246, 1, 1, h, d);
    chk("R10", "rd+wr from clear", irq_out, 0);
    // writes to other offsets leave irq alone
    io_access(16'h1245, 0, 1, h, d);
    chk("R9", "other offset no irq", irq_out, 0);

    // R7: base zero with decode enabled
    cfg_write(0, 8'h10, 8'h00); model_write(16, 8'h00);
    cfg_write(0, 8'h11, 8'h00); model_write(17, 8'h00);
    io_access(16'h0006, 0, 1, h, d);
    chk("R7", "zero base no hit", h, 0);
    chk("R9", "zero base no irq", irq_out, 0);

    // R11: reset with irq raised
    cfg_write(0, 8'h11, 8'h20); model_write(17, 8'h20);
    io_access(16'h2006, 0, 1, h, d);
    chk("R9", "irq before reset", irq_out, 1);
    do_reset();
    chk("R11", "irq after reset", irq_out, 0);
    for (int a = 0; a < 64; a++) begin
      cfg_read(0, 8'(a), d);
      chk("R11", $sformatf("post reset cfg[%02h]", a), d, exp_cfg(a));
    end
    io_access(16'h2000, 1, 0, h, d);
    chk("R11", "post reset no hit", h, 0);

    done = 1;
    summary();
    $finish;
  end

endmodule